// File: doc/BRIEF.md
# Line-Synchronised Parallel Pixel Transmitter

This block streams pixels onto a parallel bus that feeds a display panel, one word per clock, and marks every line with a single-cycle sync strobe. Each line runs as a fixed sequence: sync strobe, a programmable wait, a programmable number of pixel words, then a programmable blanking gap. A frame is a programmed number of such lines. Pixels come from a valid/ready stream. One word is taken for every pixel slot.

Software sets four configuration inputs: the wait after the sync, the number of words per line minus one, the blanking gap and the number of lines per frame. The `run` input starts a frame from idle and is only looked at on frame boundaries. If `run` is still high when a frame ends, the next frame follows without a break. If the stream has no pixel ready when a slot comes up, the bus repeats the previous word and a sticky flag records the starvation. A one-cycle pulse marks the end of each frame.

Top module: `pixel_line_tx`

## Requirements
- R1: During and right after reset, `line_sync`, `pix_en`, `frame_end`, `s_ready` and `underflow` are all 0.
- R2: Every line of a frame begins with `line_sync` high for exactly one cycle. A frame holds `cfg_lines` lines.
- R3: The first word of a line appears `cfg_delay`+1 cycles after the sync cycle. With a delay of 0 it appears in the cycle right after the sync.
- R4: A line carries exactly `cfg_words_m1`+1 words in consecutive cycles with `pix_en` high. The value 239 gives 240 words.
- R5: After the last word of a line the bus stays idle for `cfg_gap` cycles before the next sync. A gap of 0 puts the next sync in the cycle right after the last word.
- R6: A word is taken from the stream in the cycle before it is shown (`s_ready` and `s_valid` both high). Words leave in stream order on the 16-bit `pix_data`.
- R7: If `s_valid` is low while `s_ready` is high, the next `pix_data` repeats the previous word. `underflow` then goes high and stays high until reset.
- R8: `frame_end` pulses for one cycle in the cycle after the last word of the last line, and the line count returns to zero. If `run` is high at that boundary, the next frame's first sync follows after the gap. If `run` is low, the block goes idle.
- R9: The configuration is captured at the first sync of each frame. Changes made during a frame do not affect that frame.
- R10: With default parameters, a frame of 329 lines of 240 words (words-per-line value 239) runs as exactly 329 syncs and 78960 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Start or continue frames; sampled at frame boundaries |
| cfg_delay | input | 8 | Cycles between sync and first word, not counting the fixed extra cycle |
| cfg_words_m1 | input | 10 | Words per line minus one |
| cfg_gap | input | 8 | Idle cycles after the last word of a line |
| cfg_lines | input | 10 | Lines per frame |
| s_data | input | 16 | Stream pixel word |
| s_valid | input | 1 | Stream word available |
| s_ready | output | 1 | Stream word taken at this edge |
| line_sync | output | 1 | Line start strobe |
| pix_en | output | 1 | `pix_data` holds a line word |
| pix_data | output | 16 | Parallel pixel bus |
| frame_end | output | 1 | One-cycle end-of-frame pulse |
| underflow | output | 1 | Sticky stream starvation flag |

## Verification
A table of four shapes runs each frame cycle by cycle: zero delay with zero gap and back-to-back lines, single-word lines with a gap, a single long line with delay and gap, and a long delay with two-word lines. Together they separate an off-by-one in the extra post-sync cycle, in the minus-one word count and in the gap. Directed runs then cover the full 329 by 240 frame, a stream that stalls on one slot (which shows whether a word is held or dropped), a configuration change partway through a frame, and `run` held high across frames so that back-to-back frames and the stop at a boundary can be told apart.

// File: rtl/plt_pkg.sv
package plt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SYNC = 3'd1,
    ST_WAIT = 3'd2,
    ST_DATA = 3'd3,
    ST_GAP  = 3'd4
  } plt_state_e;
endpackage

// File: rtl/plt_down_cnt.sv
module plt_down_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         dec,
  input  logic [W-1:0] load_val,
  output logic         is_zero
);
  logic [W-1:0] val_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= '0;
    end else if (load) begin
      val_q <= load_val;
    end else if (dec && (val_q != '0)) begin
      val_q <= val_q - 1'b1;
    end
  end

  assign is_zero = (val_q == '0);
endmodule

// File: rtl/plt_sequencer.sv
module plt_sequencer
  import plt_pkg::*;
#(
  parameter int DLY_W  = 8,
  parameter int CNT_W  = 10,
  parameter int GAP_W  = 8,
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [DLY_W-1:0]  cfg_delay,
  input  logic [CNT_W-1:0]  cfg_words_m1,
  input  logic [GAP_W-1:0]  cfg_gap,
  input  logic [LINE_W-1:0] cfg_lines,
  output logic              line_sync_o,
  output logic              slot_o,
  output logic              slot_next_o,
  output logic              frame_end_o
);
  localparam int PH_A = (DLY_W > CNT_W) ? DLY_W : CNT_W;
  localparam int PH_W = (PH_A > GAP_W) ? PH_A : GAP_W;

  plt_state_e st_q, st_n;

  logic [DLY_W-1:0]  dly_q;
  logic [CNT_W-1:0]  words_q;
  logic [GAP_W-1:0]  gap_q;
  logic [LINE_W-1:0] lines_q;
  logic [LINE_W-1:0] line_q;
  logic [LINE_W:0]   line_nx;

  logic            ph_load, ph_dec, ph_zero;
  logic [PH_W-1:0] ph_val;
  logic            cfg_take, line_inc, line_clr, fe_n, last_line;

  assign line_nx   = {1'b0, line_q} + {{LINE_W{1'b0}}, 1'b1};
  assign last_line = (line_nx >= {1'b0, lines_q});

  plt_down_cnt #(.W(PH_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .load     (ph_load),
    .dec      (ph_dec),
    .load_val (ph_val),
    .is_zero  (ph_zero)
  );

  always_comb begin
    st_n     = st_q;
    ph_load  = 1'b0;
    ph_dec   = 1'b0;
    ph_val   = '0;
    cfg_take = 1'b0;
    line_inc = 1'b0;
    line_clr = 1'b0;
    fe_n     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (run) begin
          st_n     = ST_SYNC;
          cfg_take = 1'b1;
        end
      end
      ST_SYNC: begin
        ph_load = 1'b1;
        if (dly_q != '0) begin
          st_n   = ST_WAIT;
          ph_val = PH_W'(dly_q - 1'b1);
        end else begin
          st_n   = ST_DATA;
          ph_val = PH_W'(words_q);
        end
      end
      ST_WAIT: begin
        if (ph_zero) begin
          st_n    = ST_DATA;
          ph_load = 1'b1;
          ph_val  = PH_W'(words_q);
        end else begin
          ph_dec = 1'b1;
        end
      end
      ST_DATA: begin
        if (!ph_zero) begin
          ph_dec = 1'b1;
        end else begin
          if (last_line) begin
            line_clr = 1'b1;
            fe_n     = 1'b1;
          end else begin
            line_inc = 1'b1;
          end
          if (gap_q != '0) begin
            st_n    = ST_GAP;
            ph_load = 1'b1;
            ph_val  = PH_W'(gap_q - 1'b1);
          end else if (!last_line) begin
            st_n = ST_SYNC;
          end else if (run) begin
            st_n     = ST_SYNC;
            cfg_take = 1'b1;
          end else begin
            st_n = ST_IDLE;
          end
        end
      end
      ST_GAP: begin
        if (!ph_zero) begin
          ph_dec = 1'b1;
        end else if (line_q != '0) begin
          st_n = ST_SYNC;
        end else if (run) begin
          st_n     = ST_SYNC;
          cfg_take = 1'b1;
        end else begin
          st_n = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      line_q      <= '0;
      dly_q       <= '0;
      words_q     <= '0;
      gap_q       <= '0;
      lines_q     <= '0;
      line_sync_o <= 1'b0;
      slot_o      <= 1'b0;
      frame_end_o <= 1'b0;
    end else begin
      st_q        <= st_n;
      line_sync_o <= (st_n == ST_SYNC);
      slot_o      <= (st_n == ST_DATA);
      frame_end_o <= fe_n;
      if (line_clr) begin
        line_q <= '0;
      end else if (line_inc) begin
        line_q <= line_nx[LINE_W-1:0];
      end
      if (cfg_take) begin
        dly_q   <= cfg_delay;
        words_q <= cfg_words_m1;
        gap_q   <= cfg_gap;
        lines_q <= cfg_lines;
      end
    end
  end

  assign slot_next_o = !rst && (st_n == ST_DATA);
endmodule

// File: rtl/plt_pixel_path.sv
module plt_pixel_path #(
  parameter int PIX_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             s_valid,
  input  logic [PIX_W-1:0] s_data,
  output logic [PIX_W-1:0] pix_o,
  output logic             underflow_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pix_o       <= '0;
      underflow_o <= 1'b0;
    end else if (take) begin
      if (s_valid) begin
        pix_o <= s_data;
      end else begin
        underflow_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pixel_line_tx.sv
module pixel_line_tx #(
  parameter int PIX_W  = 16,
  parameter int DLY_W  = 8,
  parameter int CNT_W  = 10,
  parameter int GAP_W  = 8,
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [DLY_W-1:0]  cfg_delay,
  input  logic [CNT_W-1:0]  cfg_words_m1,
  input  logic [GAP_W-1:0]  cfg_gap,
  input  logic [LINE_W-1:0] cfg_lines,
  input  logic [PIX_W-1:0]  s_data,
  input  logic              s_valid,
  output logic              s_ready,
  output logic              line_sync,
  output logic              pix_en,
  output logic [PIX_W-1:0]  pix_data,
  output logic              frame_end,
  output logic              underflow
);
  logic slot_next;

  plt_sequencer #(
    .DLY_W  (DLY_W),
    .CNT_W  (CNT_W),
    .GAP_W  (GAP_W),
    .LINE_W (LINE_W)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .run          (run),
    .cfg_delay    (cfg_delay),
    .cfg_words_m1 (cfg_words_m1),
    .cfg_gap      (cfg_gap),
    .cfg_lines    (cfg_lines),
    .line_sync_o  (line_sync),
    .slot_o       (pix_en),
    .slot_next_o  (slot_next),
    .frame_end_o  (frame_end)
  );

  plt_pixel_path #(.PIX_W(PIX_W)) u_pix (
    .clk         (clk),
    .rst         (rst),
    .take        (slot_next),
    .s_valid     (s_valid),
    .s_data      (s_data),
    .pix_o       (pix_data),
    .underflow_o (underflow)
  );

  assign s_ready = slot_next;
endmodule

// File: rtl/plt_tx_chk.sv
module plt_tx_chk #(
  parameter int PIX_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             s_ready,
  input logic             s_valid,
  input logic [PIX_W-1:0] s_data,
  input logic             line_sync,
  input logic             pix_en,
  input logic [PIX_W-1:0] pix_data,
  input logic             frame_end,
  input logic             underflow
);
  // R2
  sync_single_chk: assert property (@(posedge clk) disable iff (rst)
    line_sync |=> !line_sync);

  // R5
  sync_not_data_chk: assert property (@(posedge clk) disable iff (rst)
    !(line_sync && pix_en));

  // R6
  word_in_order_chk: assert property (@(posedge clk) disable iff (rst)
    (s_ready && s_valid) |=> (pix_en && (pix_data == $past(s_data))));

  // R7
  starve_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (s_ready && !s_valid) |=> (pix_en && underflow && $stable(pix_data)));

  // R7
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    underflow |=> underflow);

  // R8
  frame_end_single_chk: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> !frame_end);

  // R8
  frame_end_idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> !pix_en);
endmodule

bind pixel_line_tx plt_tx_chk #(.PIX_W(PIX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .s_ready   (s_ready),
  .s_valid   (s_valid),
  .s_data    (s_data),
  .line_sync (line_sync),
  .pix_en    (pix_en),
  .pix_data  (pix_data),
  .frame_end (frame_end),
  .underflow (underflow)
);

// File: tb/pixel_line_tx_tb.sv
module pixel_line_tx_tb;
  localparam int CLK_P = 10;
  // fields: delay, words-1, gap, lines
  localparam logic [31:0] VEC [4] = '{
    32'h00_03_00_02,
    32'h02_00_01_03,
    32'h01_04_02_01,
    32'h03_01_00_02
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic [7:0]  cfg_delay = '0;
  logic [9:0]  cfg_words_m1 = '0;
  logic [7:0]  cfg_gap = '0;
  logic [9:0]  cfg_lines = '0;
  logic [15:0] s_data;
  logic        s_valid = 1'b1;
  logic        s_ready, line_sync, pix_en, frame_end, underflow;
  logic [15:0] pix_data;
  logic [15:0] src_q;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  always_ff @(posedge clk) begin
    if (rst) src_q <= 16'h1000;
    else if (s_ready && s_valid) src_q <= src_q + 16'd1;
  end
  assign s_data = src_q;

  pixel_line_tx u_dut (
    .clk(clk), .rst(rst), .run(run), .cfg_delay(cfg_delay),
    .cfg_words_m1(cfg_words_m1), .cfg_gap(cfg_gap), .cfg_lines(cfg_lines),
    .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .line_sync(line_sync), .pix_en(pix_en), .pix_data(pix_data),
    .frame_end(frame_end), .underflow(underflow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; run = 1'b0; s_valid = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic start(input int d, input int nm1, input int g, input int l);
    cfg_delay = 8'(d); cfg_words_m1 = 10'(nm1); cfg_gap = 8'(g); cfg_lines = 10'(l);
    run = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int d, nm1, n, g, l, p, fe_i, es, ee, ed, ef, cs, cw, cf;
    // reset state
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk({line_sync, pix_en, frame_end, s_ready, underflow} == 5'b0, "R1 in reset",
        int'({line_sync, pix_en, frame_end, s_ready, underflow}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk({line_sync, pix_en, frame_end, s_ready, underflow} == 5'b0, "R1 after reset",
        int'({line_sync, pix_en, frame_end, s_ready, underflow}), 0);

    // table-driven frame shapes
    for (int v = 0; v < 4; v++) begin
      d = int'(VEC[v][31:24]); nm1 = int'(VEC[v][23:16]);
      g = int'(VEC[v][15:8]);  l = int'(VEC[v][7:0]);
      n = nm1 + 1; p = 1 + d + n + g; fe_i = (l - 1) * p + d + n + 1;
      es = 0; ee = 0; ed = 0; ef = 0;
      do_reset();
      start(d, nm1, g, l);
      for (int idx = 0; idx <= l * p + 3; idx++) begin
        int pos, ln;
        bit xs, xe;
        ln = idx / p; pos = idx % p;
        xs = (idx < l * p) && (pos == 0);
        xe = (idx < l * p) && (pos >= 1 + d) && (pos <= d + n);
        if (line_sync !== xs) es++;
        if (pix_en !== xe) ee++;
        if (xe && (pix_data !== 16'(4096 + ln * n + pos - 1 - d))) ed++;
        if (frame_end !== (idx == fe_i)) ef++;
        run = 1'b0;
        @(negedge clk);
      end
      chk(es == 0, "R2 sync positions", es, 0);
      chk(ee == 0, "R3 R4 R5 word slots", ee, 0);
      chk(ed == 0, "R6 word values", ed, 0);
      chk(ef == 0, "R8 frame end", ef, 0);
    end

    // full-size frame
    do_reset();
    start(0, 239, 0, 329);
    run = 1'b0;
    cs = 0; cw = 0; cf = 0;
    for (int idx = 0; idx < 329 * 241 + 10; idx++) begin
      cs += int'(line_sync); cw += int'(pix_en); cf += int'(frame_end);
      @(negedge clk);
    end
    chk(cs == 329, "R10 R2 sync count", cs, 329);
    chk(cw == 78960, "R10 R4 word count", cw, 78960);
    chk(cf == 1, "R10 R8 frame end count", cf, 1);
    chk(underflow == 1'b0, "R7 no underflow on full stream", int'(underflow), 0);

    // stalled stream
    do_reset();
    start(0, 3, 0, 1);
    run = 1'b0;
    @(negedge clk); @(negedge clk);          // idx 2
    chk(underflow == 1'b0, "R7 before stall", int'(underflow), 0);
    s_valid = 1'b0;
    @(negedge clk);                          // idx 3
    chk(pix_data == 16'h1001, "R7 word held", int'(pix_data), 16'h1001);
    chk(underflow == 1'b1, "R7 flag set", int'(underflow), 1);
    s_valid = 1'b1;
    @(negedge clk);                          // idx 4
    chk(pix_data == 16'h1002, "R7 R6 next word not lost", int'(pix_data), 16'h1002);
    repeat (4) @(negedge clk);
    chk(underflow == 1'b1, "R7 flag sticky", int'(underflow), 1);

    // configuration change mid-frame
    do_reset();
    start(0, 3, 1, 2);
    run = 1'b0;
    cw = 0; cf = 0; cs = 0;
    for (int idx = 0; idx <= 16; idx++) begin
      cw += int'(pix_en);
      if (frame_end) cf = idx;
      if (line_sync && idx == 6) cs = 1;
      if (idx == 2) begin cfg_words_m1 = 10'd7; cfg_delay = 8'd2; end
      @(negedge clk);
    end
    chk(cw == 8, "R9 words with changed config", cw, 8);
    chk(cf == 11, "R9 frame end position", cf, 11);
    chk(cs == 1, "R9 second sync position", cs, 1);

    // run held across frames
    do_reset();
    start(1, 1, 0, 2);
    cs = 0; cf = 0; cw = 0;
    for (int idx = 0; idx <= 40; idx++) begin
      cs += int'(line_sync); cf += int'(frame_end);
      if (idx == 8 && line_sync && frame_end) cw++;
      if (idx == 16 && line_sync && frame_end) cw++;
      if (idx == 17) run = 1'b0;
      @(negedge clk);
    end
    chk(cw == 2, "R8 next frame starts at boundary", cw, 2);
    chk(cs == 6, "R8 R2 syncs until stop", cs, 6);
    chk(cf == 3, "R8 frames until stop", cf, 3);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule